// File: doc/BRIEF.md
# Indirect-Access Interrupt Routing Table

This block is the register side of an I/O interrupt controller. Software sees only two 32-bit locations on a small memory-mapped slave bus. One is a select register that names an internal register. The other is a data window that reads or writes the internal register the select register names. Behind the window are three registers and a routing table. The first register holds a 4-bit identification field. The second is a fixed version word that reports the table size. The third is an arbitration word that mirrors the identification register. The routing table holds one 64-bit entry per interrupt pin. Software reaches each entry as two 32-bit halves.

The delivery engine, which is outside this block, reads whole entries through a lookup port that has one cycle of latency. It sets or clears each pin's remote-IRR status bit through a side port. Software cannot change that status bit or the delivery-status bit. When a software write changes a part of an entry that affects how interrupts are routed, the block emits a one-cycle recalculation pulse that carries the pin number. Changes to the mask bit or the polarity bit alone do not produce the pulse. Every pin comes out of reset masked.

Top module: `irq_route_regs`

## Requirements
- R1: An access takes effect only when `bus_full` is 1 and `bus_addr` is 0x00 (select) or 0x10 (window). Any other read returns zero, and any other write changes no state.
- R2: Read data appears on `bus_rdata` in the cycle after the read request. `bus_rdata` is zero in every cycle that does not follow a read.
- R3: The select register stores all 32 written bits and reads them back at offset 0x00. Its low 8 bits are the register number that the window uses.
- R4: Register number 0x00 (identification) keeps only bits 27:24 of a write and reads back those bits in place. Register number 0x02 (arbitration) reads the same word, and writes to it are dropped.
- R5: Register number 0x01 (version) reads ((entries−1) << 16) | 0x11, which is 0x001F0011 for 32 entries. Writes to it are dropped.
- R6: Entry p is reached at register number 0x10+2p for bits 31:0 and at 0x11+2p for bits 63:32.
- R7: After reset every entry is 0x0001000000010000, so every pin is masked (mask bit 16).
- R8: Bit 12 (delivery status) and bit 14 (remote IRR) of an entry keep their current values whatever a window write supplies.
- R9: When `rirr_valid` is 1, bit 14 of entry `rirr_pin` becomes `rirr_set`. The new value is visible through the window and through the lookup port.
- R10: One cycle after a window write that changes any entry bit other than 13 (polarity) and 16 (mask), `recalc_pulse` is high for exactly one cycle and `recalc_pin` names the pin. A write that changes only those two bits, or changes nothing, gives no pulse.
- R11: Register numbers 0x03–0x0F and 0x50–0xFF read zero, and writes to them change nothing.
- R12: `look_entry` holds the full 64-bit entry of `look_pin` one cycle after `look_pin` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_full | input | 1 | 1 = full 32-bit access |
| bus_addr | input | 8 | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rirr_valid | input | 1 | Remote-IRR update strobe from the delivery engine |
| rirr_pin | input | 5 | Pin to update |
| rirr_set | input | 1 | New remote-IRR value |
| look_pin | input | 5 | Pin whose entry is exported |
| look_entry | output | 64 | Registered 64-bit entry of `look_pin` |
| recalc_pulse | output | 1 | One-cycle recalculation notice |
| recalc_pin | output | 5 | Pin that caused the notice |

## Verification
The assertions check four rules on every cycle. The select register and the identification field change only in the cycle after a write aimed at them. Remote IRR changes only after a side-port strobe. The delivery-status bit never reads as one. Read data is zero whenever no read preceded it. Other behaviours can only be shown by the bench's scenarios, each driven to a known expected value. These are the half-to-index mapping, the masking of read-only bits inside a write, the absence of a pulse for mask-only and polarity-only edits, the behaviour of undefined register numbers and bad-size accesses, and the last table entry.

// File: rtl/irt_pkg.sv
package irt_pkg;
  localparam int unsigned HALF_W  = 32;
  localparam int unsigned B_DSTAT = 12;
  localparam int unsigned B_POL   = 13;
  localparam int unsigned B_RIRR  = 14;
  localparam int unsigned B_MASK  = 16;
  localparam int unsigned ID_LSB  = 24;
  localparam int unsigned ID_W    = 4;
  localparam int unsigned MAXE_LSB = 16;

  // status bits software may not alter
  localparam logic [HALF_W-1:0] LO_RO_BITS   = (32'h1 << B_DSTAT) | (32'h1 << B_RIRR);
  // bits whose change does not require trigger-mode recalculation
  localparam logic [HALF_W-1:0] LO_QUIET_BITS = (32'h1 << B_POL) | (32'h1 << B_MASK);
  localparam logic [HALF_W-1:0] HALF_RESET    = 32'h0001_0000;
endpackage

// File: rtl/irt_bus_if.sv
module irt_bus_if #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SEL_OFF = 8'h00,
  parameter logic [ADDR_W-1:0] WIN_OFF = 8'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_full,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       sel_q,
  output logic              sel_rd,
  output logic              win_rd,
  output logic              win_wr
);
  logic legal_acc, sel_hit, win_hit, sel_wr;

  always_comb begin
    legal_acc = bus_valid && bus_full;
    sel_hit   = legal_acc && (bus_addr == SEL_OFF);
    win_hit   = legal_acc && (bus_addr == WIN_OFF);
    sel_wr    = sel_hit && bus_write;
    sel_rd    = sel_hit && !bus_write;
    win_rd    = win_hit && !bus_write;
    win_wr    = win_hit && bus_write;
  end

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= '0;
    else if (sel_wr) sel_q <= bus_wdata;
  end

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
    !$past(sel_wr) |-> $stable(sel_q)); // R3
endmodule

// File: rtl/irt_table.sv
module irt_table
  import irt_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 32,
  localparam int unsigned PIN_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [PIN_W-1:0] wr_pin,
  input  logic             wr_hi,
  input  logic [31:0]      wr_data,
  input  logic [PIN_W-1:0] rd_pin,
  input  logic             rd_hi,
  output logic [31:0]      rd_data,
  input  logic             rirr_valid,
  input  logic [PIN_W-1:0] rirr_pin,
  input  logic             rirr_set,
  input  logic [PIN_W-1:0] look_pin,
  output logic [63:0]      look_entry,
  output logic             recalc_pulse,
  output logic [PIN_W-1:0] recalc_pin
);
  logic [31:0] lo_mem [NUM_ENTRIES];
  logic [31:0] hi_mem [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] rirr_q;

  logic [31:0] old_half, new_half, watch_bits;
  logic        route_change;

  always_comb begin
    old_half   = wr_hi ? hi_mem[wr_pin] : lo_mem[wr_pin];
    new_half   = wr_hi ? wr_data : ((wr_data & ~LO_RO_BITS) | (old_half & LO_RO_BITS));
    watch_bits = wr_hi ? '1 : ~LO_QUIET_BITS;
    route_change = |((old_half ^ new_half) & watch_bits);
    rd_data    = rd_hi ? hi_mem[rd_pin]
                       : (lo_mem[rd_pin] | (32'(rirr_q[rd_pin]) << B_RIRR));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        lo_mem[i] <= HALF_RESET;
        hi_mem[i] <= HALF_RESET;
      end
    end else if (wr_en) begin
      if (wr_hi) hi_mem[wr_pin] <= new_half;
      else       lo_mem[wr_pin] <= new_half;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             rirr_q <= '0;
    else if (rirr_valid) rirr_q[rirr_pin] <= rirr_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      recalc_pulse <= 1'b0;
      recalc_pin   <= '0;
      look_entry   <= '0;
    end else begin
      recalc_pulse <= wr_en && route_change;
      if (wr_en) recalc_pin <= wr_pin;
      look_entry <= {hi_mem[look_pin],
                     lo_mem[look_pin] | (32'(rirr_q[look_pin]) << B_RIRR)};
    end
  end

  AST_RIRR_SIDE_ONLY: assert property (@(posedge clk) disable iff (rst)
    !$past(rirr_valid) |-> $stable(rirr_q)); // R9
  AST_DSTAT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !rd_data[B_DSTAT] || rd_hi); // R8
  AST_RECALC_CAUSE: assert property (@(posedge clk) disable iff (rst)
    recalc_pulse |-> $past(wr_en)); // R10
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irt_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 32,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SEL_OFF = 8'h00,
  parameter logic [ADDR_W-1:0] WIN_OFF = 8'h10,
  parameter logic [7:0] TABLE_BASE = 8'h10,
  localparam int unsigned PIN_W = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_full,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rirr_valid,
  input  logic [PIN_W-1:0]  rirr_pin,
  input  logic              rirr_set,
  input  logic [PIN_W-1:0]  look_pin,
  output logic [63:0]       look_entry,
  output logic              recalc_pulse,
  output logic [PIN_W-1:0]  recalc_pin
);
  localparam int unsigned TBL_SPAN = 2 * NUM_ENTRIES;
  localparam logic [7:0]  NUM_ID  = 8'h00;
  localparam logic [7:0]  NUM_VER = 8'h01;
  localparam logic [7:0]  NUM_ARB = 8'h02;
  localparam logic [31:0] VER_WORD = (32'(NUM_ENTRIES - 1) << MAXE_LSB) | 32'h11;

  logic [31:0]     sel_q;
  logic            sel_rd, win_rd, win_wr;
  logic [7:0]      regnum;
  logic [PIN_W:0]  tbl_off;
  logic            in_tbl, id_wr, tbl_wr;
  logic [31:0]     tbl_rdata, win_value, id_word;
  logic [ID_W-1:0] id_q;

  irt_bus_if #(.ADDR_W(ADDR_W), .SEL_OFF(SEL_OFF), .WIN_OFF(WIN_OFF)) u_bus (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_full(bus_full), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .sel_q(sel_q), .sel_rd(sel_rd), .win_rd(win_rd), .win_wr(win_wr));

  always_comb begin
    regnum  = sel_q[7:0];
    tbl_off = (PIN_W+1)'(regnum - TABLE_BASE);
    in_tbl  = (int'(regnum) >= int'(TABLE_BASE)) &&
              (int'(regnum) <  int'(TABLE_BASE) + int'(TBL_SPAN));
    id_wr   = win_wr && (regnum == NUM_ID);
    tbl_wr  = win_wr && in_tbl;
    id_word = 32'(id_q) << ID_LSB;
    if (in_tbl)                  win_value = tbl_rdata;
    else if (regnum == NUM_ID)   win_value = id_word;
    else if (regnum == NUM_VER)  win_value = VER_WORD;
    else if (regnum == NUM_ARB)  win_value = id_word;
    else                         win_value = '0;
  end

  irt_table #(.NUM_ENTRIES(NUM_ENTRIES)) u_tbl (
    .clk(clk), .rst(rst),
    .wr_en(tbl_wr), .wr_pin(tbl_off[PIN_W:1]), .wr_hi(tbl_off[0]), .wr_data(bus_wdata),
    .rd_pin(tbl_off[PIN_W:1]), .rd_hi(tbl_off[0]), .rd_data(tbl_rdata),
    .rirr_valid(rirr_valid), .rirr_pin(rirr_pin), .rirr_set(rirr_set),
    .look_pin(look_pin), .look_entry(look_entry),
    .recalc_pulse(recalc_pulse), .recalc_pin(recalc_pin));

  always_ff @(posedge clk) begin
    if (rst)        id_q <= '0;
    else if (id_wr) id_q <= bus_wdata[ID_LSB +: ID_W];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (sel_rd) bus_rdata <= sel_q;
    else if (win_rd) bus_rdata <= win_value;
    else             bus_rdata <= '0;
  end

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_valid && !bus_write) |-> (bus_rdata == '0)); // R2
  AST_ID_HELD: assert property (@(posedge clk) disable iff (rst)
    !$past(id_wr) |-> $stable(id_q)); // R4
endmodule

// File: tb/irq_route_regs_tb.sv
`timescale 1ns/1ps
module irq_route_regs_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 0, bus_write = 0, bus_full = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic rirr_valid = 0, rirr_set = 0;
  logic [4:0] rirr_pin = '0, look_pin = '0, recalc_pin;
  logic [63:0] look_entry;
  logic recalc_pulse;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_route_regs u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_full(bus_full), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rirr_valid(rirr_valid), .rirr_pin(rirr_pin),
    .rirr_set(rirr_set), .look_pin(look_pin), .look_entry(look_entry),
    .recalc_pulse(recalc_pulse), .recalc_pin(recalc_pin));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d, logic full,
                        output logic pulse, output logic [4:0] ppin);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_full = full; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    pulse = recalc_pulse; ppin = recalc_pin;
  endtask

  task automatic bus_rd(logic [7:0] a, logic full, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_full = full; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    d = bus_rdata;
  endtask

  task automatic wreg(logic [7:0] r, logic [31:0] d, output logic pulse, output logic [4:0] ppin);
    logic p0; logic [4:0] q0;
    bus_wr(8'h00, {24'h0, r}, 1'b1, p0, q0);
    bus_wr(8'h10, d, 1'b1, pulse, ppin);
  endtask

  task automatic rreg(logic [7:0] r, output logic [31:0] d);
    logic p0; logic [4:0] q0;
    bus_wr(8'h00, {24'h0, r}, 1'b1, p0, q0);
    bus_rd(8'h10, 1'b1, d);
  endtask

  task automatic lookup(logic [4:0] p, output logic [63:0] e);
    @(negedge clk); look_pin = p;
    @(negedge clk); e = look_entry;
  endtask

  task automatic side(logic [4:0] p, logic v);
    @(negedge clk); rirr_valid = 1; rirr_pin = p; rirr_set = v;
    @(negedge clk); rirr_valid = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic [63:0] e;
    check("R2 idle rdata", {32'h0, bus_rdata}, 64'h0);
    rreg(8'h10, d); check("R7 pin0 low", {32'h0, d}, 64'h0001_0000);
    rreg(8'h11, d); check("R7 pin0 high", {32'h0, d}, 64'h0001_0000);
    lookup(5'd5, e); check("R7/R12 lookup pin5", e, 64'h0001_0000_0001_0000);
    rreg(8'h01, d); check("R5 version", {32'h0, d}, 64'h001F_0011);
    @(negedge clk); check("R2 rdata clears", {32'h0, bus_rdata}, 64'h0);
  endtask

  task automatic t_select_and_bad;
    logic [31:0] d; logic p; logic [4:0] q;
    bus_wr(8'h00, 32'hABCD_0001, 1'b1, p, q);
    bus_rd(8'h00, 1'b1, d); check("R3 select readback", {32'h0, d}, 64'hABCD_0001);
    bus_rd(8'h10, 1'b1, d); check("R3 low byte selects version", {32'h0, d}, 64'h001F_0011);
    bus_wr(8'h00, 32'h0000_0002, 1'b0, p, q);
    bus_rd(8'h00, 1'b1, d); check("R1 narrow write ignored", {32'h0, d}, 64'hABCD_0001);
    bus_wr(8'h04, 32'h0000_0003, 1'b1, p, q);
    bus_rd(8'h00, 1'b1, d); check("R1 bad offset write ignored", {32'h0, d}, 64'hABCD_0001);
    bus_rd(8'h08, 1'b1, d); check("R1 bad offset read zero", {32'h0, d}, 64'h0);
    bus_rd(8'h00, 1'b0, d); check("R1 narrow read zero", {32'h0, d}, 64'h0);
    bus_wr(8'h00, 32'h0, 1'b1, p, q);
    bus_wr(8'h10, 32'hFFFF_FFFF, 1'b0, p, q);
    bus_rd(8'h10, 1'b1, d); check("R1 narrow window write ignored", {32'h0, d}, 64'h0);
  endtask

  task automatic t_id_regs;
    logic [31:0] d; logic p; logic [4:0] q;
    wreg(8'h00, 32'hFFFF_FFFF, p, q);
    rreg(8'h00, d); check("R4 id field only", {32'h0, d}, 64'h0F00_0000);
    rreg(8'h02, d); check("R4 arbitration mirrors id", {32'h0, d}, 64'h0F00_0000);
    wreg(8'h02, 32'h1234_5678, p, q);
    rreg(8'h00, d); check("R4 arbitration write dropped", {32'h0, d}, 64'h0F00_0000);
    wreg(8'h01, 32'h0, p, q);
    rreg(8'h01, d); check("R5 version write dropped", {32'h0, d}, 64'h001F_0011);
  endtask

  task automatic t_entries;
    logic [31:0] d; logic p; logic [4:0] q; logic [63:0] e;
    wreg(8'h16, 32'h0000_80A5, p, q);
    check("R10 pulse on vector/trigger", {63'h0, p}, 64'h1);
    check("R10 pulse pin", {59'h0, q}, 64'd3);
    @(negedge clk); check("R10 pulse one cycle", {63'h0, recalc_pulse}, 64'h0);
    rreg(8'h16, d); check("R6 pin3 low", {32'h0, d}, 64'h0000_80A5);
    wreg(8'h17, 32'h0F00_0000, p, q);
    check("R10 pulse on high half", {58'h0, p, q}, {58'h0, 1'b1, 5'd3});
    rreg(8'h17, d); check("R6 pin3 high", {32'h0, d}, 64'h0F00_0000);
    lookup(5'd3, e); check("R12 lookup pin3", e, 64'h0F00_0000_0000_80A5);
    wreg(8'h1E, 32'hFFFF_FFFF, p, q);
    rreg(8'h1E, d); check("R8 ro bits kept pin7", {32'h0, d}, 64'hFFFF_AFFF);
    check("R10 pulse pin7", {58'h0, p, q}, {58'h0, 1'b1, 5'd7});
    rreg(8'h1F, d); check("R6 pin7 high untouched", {32'h0, d}, 64'h0001_0000);
  endtask

  task automatic t_quiet_bits;
    logic [31:0] d; logic p; logic [4:0] q;
    wreg(8'h16, 32'h0001_80A5, p, q); check("R10 mask only no pulse", {63'h0, p}, 64'h0);
    wreg(8'h16, 32'h0001_A0A5, p, q); check("R10 polarity only no pulse", {63'h0, p}, 64'h0);
    wreg(8'h16, 32'h0001_A0A5, p, q); check("R10 same value no pulse", {63'h0, p}, 64'h0);
    rreg(8'h16, d); check("R6 pin3 after quiet edits", {32'h0, d}, 64'h0001_A0A5);
  endtask

  task automatic t_side_port;
    logic [31:0] d; logic p; logic [4:0] q; logic [63:0] e;
    side(5'd3, 1'b1);
    rreg(8'h16, d); check("R9 rirr set visible", {32'h0, d}, 64'h0001_E0A5);
    wreg(8'h16, 32'h0001_20A5, p, q);
    check("R10 trigger change pulses", {63'h0, p}, 64'h1);
    rreg(8'h16, d); check("R8 rirr survives write", {32'h0, d}, 64'h0001_60A5);
    lookup(5'd3, e); check("R9/R12 lookup with rirr", e, 64'h0F00_0000_0001_60A5);
    side(5'd3, 1'b0);
    rreg(8'h16, d); check("R9 rirr cleared", {32'h0, d}, 64'h0001_20A5);
    wreg(8'h16, 32'h0001_70A5, p, q);
    check("R8 ro-only write no pulse", {63'h0, p}, 64'h0);
    rreg(8'h16, d); check("R8 ro bits unchanged", {32'h0, d}, 64'h0001_20A5);
  endtask

  task automatic t_undefined;
    logic [31:0] d; logic p; logic [4:0] q;
    rreg(8'h03, d); check("R11 num 0x03", {32'h0, d}, 64'h0);
    rreg(8'h0F, d); check("R11 num 0x0F", {32'h0, d}, 64'h0);
    rreg(8'hFF, d); check("R11 num 0xFF", {32'h0, d}, 64'h0);
    wreg(8'h50, 32'hDEAD_BEEF, p, q); check("R11 write 0x50 no pulse", {63'h0, p}, 64'h0);
    rreg(8'h50, d); check("R11 num 0x50", {32'h0, d}, 64'h0);
    rreg(8'h4F, d); check("R11 pin31 high untouched", {32'h0, d}, 64'h0001_0000);
    wreg(8'h4E, 32'h0001_0033, p, q);
    check("R10 pin31 pulse", {58'h0, p, q}, {58'h0, 1'b1, 5'd31});
    rreg(8'h4E, d); check("R6 pin31 low", {32'h0, d}, 64'h0001_0033);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_select_and_bad();
    t_id_regs();
    t_entries();
    t_quiet_bits();
    t_side_port();
    t_undefined();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule